// File: doc/BRIEF.md
# Horizontal Line Crop Stage

This block sits in a streaming pixel path between a line fetcher and a compositor. Every input line is cut down to a programmed window of columns. The stage drops a programmable number of pixels at the left edge and at the right edge. The kept pixels pass through unchanged and in order. Lines are never removed, so the output frame has exactly as many lines as the input frame. Both sides of the block use a valid/ready pixel stream. The stream carries a start-of-line marker and an end-of-frame marker.

Configuration arrives on shadow inputs: input width minus one, line count minus one, left drop count, right drop value and a bypass bit. A small state machine with three states decides when the configuration takes effect:

- **ST_LOAD**: a one-cycle frame-boundary state in which the shadow values are copied into the active registers, unless the hold input is asserted.
- **ST_CROP**: applies the column window.
- **ST_PASS**: forwards the stream untouched.

The transitions are:

- **LOAD→CROP**: the effective bypass bit is 0.
- **LOAD→PASS**: the effective bypass bit is 1.
- **CROP→LOAD** and **PASS→LOAD**: an end-of-frame pixel is accepted.

Reset enters ST_LOAD.

Inside ST_CROP the column position comes from an internal counter that wraps at the active width. The output markers are regenerated from the window, so the input markers are not used there.

Top module: `hcrop_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `s_ready` and `m_valid` are both 0.
- R2: With the active bypass bit at 1 (state ST_PASS), every input pixel appears on the output in the same cycle. Data, `m_sol` and `m_eof` equal the input, and `s_ready` equals `m_ready`.
- R3: In crop mode, with active width-minus-one Wm, left count L and right value R, a pixel at column c (counted from 0 along the line) is kept exactly when L <= c and c + R + 1 <= Wm. Kept pixels leave with their data unchanged and in input order.
- R4: In crop mode a dropped pixel is consumed from the input (`s_ready`=1) without `m_valid`, whatever the level of `m_ready`.
- R5: In crop mode `m_sol` is 1 only on the kept pixel at column L of each line.
- R6: In crop mode `m_eof` is 1 only on the kept pixel with c + R + 1 = Wm on line number Hm, the active line count minus one. Every input line yields one output line.
- R7: After reset, and after every accepted pixel with `s_eof`=1, the stage spends exactly one cycle in ST_LOAD with `s_ready`=0 and `m_valid`=0, loading the shadow inputs. Shadow values that change during a frame have no effect on that frame.
- R8: If `cfg_hold` is 1 in the ST_LOAD cycle, the active configuration keeps its previous value. The reset values are bypass=1 and all counts 0.
- R9: A kept pixel presented while `m_ready` is 0 is not consumed: `s_ready` is 0 and `m_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width_m1 | input | CNT_W | Shadow: input line width minus one |
| cfg_height_m1 | input | CNT_W | Shadow: lines per frame minus one |
| cfg_left | input | CNT_W | Shadow: pixels dropped at the line start |
| cfg_right | input | CNT_W | Shadow: right drop value (pixels dropped at the line end minus one) |
| cfg_bypass | input | 1 | Shadow: 1 forwards the stream uncropped |
| cfg_hold | input | 1 | 1 blocks the frame-boundary load |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted this cycle when valid |
| s_data | input | DATA_W | Input pixel |
| s_sol | input | 1 | Input start-of-line marker |
| s_eof | input | 1 | Input end-of-frame marker (last pixel of frame) |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Output pixel |
| m_sol | output | 1 | Output start-of-line marker |
| m_eof | output | 1 | Output end-of-frame marker |

## Verification
Two functions can fall in the same cycle:

- dropping a pixel that lies outside the window;
- stalling on downstream backpressure.

When they coincide, the drop must win: the pixel is consumed even though `m_ready` is low.

The bench holds `m_ready` low one cycle in three across a sweep over every legal left/right pair for several widths. This makes dropped columns at both edges meet a low `m_ready` many times. For each such cycle the bench requires `s_ready` high and `m_valid` low. For a kept pixel under a low `m_ready` it requires `s_ready` low and the pixel to be presented again in the next cycle.

// File: rtl/hcrop_pkg.sv
package hcrop_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_CROP = 2'd1,
        ST_PASS = 2'd2
    } hc_state_t;
endpackage

// File: rtl/hcrop_shadow.sv
module hcrop_shadow #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             hold,
    input  logic [CNT_W-1:0] in_width_m1,
    input  logic [CNT_W-1:0] in_height_m1,
    input  logic [CNT_W-1:0] in_left,
    input  logic [CNT_W-1:0] in_right,
    input  logic             in_bypass,
    output logic [CNT_W-1:0] act_width_m1,
    output logic [CNT_W-1:0] act_height_m1,
    output logic [CNT_W-1:0] act_left,
    output logic [CNT_W-1:0] act_right,
    output logic             act_bypass
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_width_m1  <= '0;
            act_height_m1 <= '0;
            act_left      <= '0;
            act_right     <= '0;
            act_bypass    <= 1'b1;
        end else if (load && !hold) begin
            act_width_m1  <= in_width_m1;
            act_height_m1 <= in_height_m1;
            act_left      <= in_left;
            act_right     <= in_right;
            act_bypass    <= in_bypass;
        end
    end

    // R7 / R8: active configuration moves only on an unheld load
    a_r8_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && !hold) |=> $stable({act_width_m1, act_height_m1, act_left, act_right, act_bypass}));
endmodule

// File: rtl/hcrop_pos.sv
module hcrop_pos #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] width_m1,
    output logic [CNT_W-1:0] col,
    output logic [CNT_W-1:0] line
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            col  <= '0;
            line <= '0;
        end else if (step) begin
            if (col == width_m1) begin
                col  <= '0;
                line <= line + 1'b1;
            end else begin
                col  <= col + 1'b1;
            end
        end
    end

    // R3: column position never runs past the active width
    a_r3_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (col <= width_m1));
endmodule

// File: rtl/hcrop_window.sv
module hcrop_window #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] col,
    input  logic [CNT_W-1:0] line,
    input  logic [CNT_W-1:0] width_m1,
    input  logic [CNT_W-1:0] height_m1,
    input  logic [CNT_W-1:0] left,
    input  logic [CNT_W-1:0] right,
    output logic             keep,
    output logic             first,
    output logic             last_out
);
    localparam int XW = CNT_W + 2;

    logic [XW-1:0] reach;
    logic [XW-1:0] limit;

    always_comb begin
        reach    = XW'(col) + XW'(right) + XW'(1);
        limit    = XW'(width_m1);
        keep     = (col >= left) && (reach <= limit);
        first    = keep && (col == left);
        last_out = keep && (reach == limit) && (line == height_m1);
    end
endmodule

// File: rtl/hcrop_stage.sv
module hcrop_stage
    import hcrop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_width_m1,
    input  logic [CNT_W-1:0]  cfg_height_m1,
    input  logic [CNT_W-1:0]  cfg_left,
    input  logic [CNT_W-1:0]  cfg_right,
    input  logic              cfg_bypass,
    input  logic              cfg_hold,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_sol,
    input  logic              s_eof,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_sol,
    output logic              m_eof
);
    hc_state_t st_q, st_nx;

    logic [CNT_W-1:0] act_w, act_h, act_l, act_r;
    logic             act_byp;
    logic [CNT_W-1:0] col, line;
    logic             keep, first, eof_out;
    logic             load, accept, step, eff_byp;

    assign load    = (st_q == ST_LOAD);
    assign accept  = s_valid && s_ready;
    assign step    = accept && (st_q == ST_CROP);
    assign eff_byp = cfg_hold ? act_byp : cfg_bypass;

    hcrop_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load), .hold(cfg_hold),
        .in_width_m1(cfg_width_m1), .in_height_m1(cfg_height_m1),
        .in_left(cfg_left), .in_right(cfg_right), .in_bypass(cfg_bypass),
        .act_width_m1(act_w), .act_height_m1(act_h),
        .act_left(act_l), .act_right(act_r), .act_bypass(act_byp)
    );

    hcrop_pos #(.CNT_W(CNT_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .clr(load), .step(step),
        .width_m1(act_w), .col(col), .line(line)
    );

    hcrop_window #(.CNT_W(CNT_W)) u_win (
        .col(col), .line(line), .width_m1(act_w), .height_m1(act_h),
        .left(act_l), .right(act_r),
        .keep(keep), .first(first), .last_out(eof_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOAD;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_LOAD: st_nx = eff_byp ? ST_PASS : ST_CROP;
            ST_CROP,
            ST_PASS: if (accept && s_eof) st_nx = ST_LOAD;
            default: st_nx = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        s_ready = 1'b0;
        m_valid = 1'b0;
        m_sol   = 1'b0;
        m_eof   = 1'b0;
        m_data  = s_data;
        unique case (st_q)
            ST_LOAD: ;
            ST_PASS: begin
                s_ready = m_ready;
                m_valid = s_valid;
                m_sol   = s_sol;
                m_eof   = s_eof;
            end
            ST_CROP: begin
                if (keep) begin
                    s_ready = m_ready;
                    m_valid = s_valid;
                    m_sol   = first;
                    m_eof   = eof_out;
                end else begin
                    s_ready = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // R4: a dropped pixel is swallowed with no output
    a_r4_drop_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CROP && s_valid && !keep) |-> (s_ready && !m_valid));
    // R5: output line start sits on the left edge of the window
    a_r5_sol_at_left: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CROP && m_valid && m_sol) |-> (col == act_l));
    // R7: accepted end of frame is followed by the load cycle
    a_r7_eof_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_eof) |=> (!s_ready && !m_valid));
    // R9: a stalled output holds the input
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |-> !s_ready);
endmodule

// File: tb/hcrop_stage_tb.sv
module hcrop_stage_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_width_m1, cfg_height_m1, cfg_left, cfg_right;
    logic       cfg_bypass, cfg_hold;
    logic       s_valid, s_ready, s_sol, s_eof;
    logic [7:0] s_data, m_data;
    logic       m_valid, m_ready, m_sol, m_eof;

    int checks = 0;
    int errors = 0;
    int rdy_ctr = 0;
    bit done = 0;
    // bench model of the active configuration (reset values per R8)
    int a_w = 0, a_h = 0, a_l = 0, a_r = 0;
    bit a_b = 1;

    always #5 clk = ~clk;

    hcrop_stage u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_width_m1(cfg_width_m1), .cfg_height_m1(cfg_height_m1),
        .cfg_left(cfg_left), .cfg_right(cfg_right),
        .cfg_bypass(cfg_bypass), .cfg_hold(cfg_hold),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_sol(s_sol), .s_eof(s_eof),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_sol(m_sol), .m_eof(m_eof)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic send_pixel(input logic [7:0] d, input bit sol, input bit eof,
                              input bit kp, input bit es, input bit ee,
                              input bit byp, input string rq);
        bit acc;
        do begin
            s_valid = 1'b1; s_data = d; s_sol = sol; s_eof = eof;
            m_ready = (rdy_ctr % 3) != 2;
            rdy_ctr++;
            #4;
            if (kp) begin
                chk(m_valid === 1'b1, rq, m_valid, 1);
                chk(m_data === d, rq, m_data, d);
                chk(m_sol === es, byp ? "R2" : "R5", m_sol, es);
                chk(m_eof === ee, byp ? "R2" : "R6", m_eof, ee);
                chk(s_ready === m_ready, "R9", s_ready, m_ready);
            end else begin
                chk(m_valid === 1'b0 && s_ready === 1'b1, "R4",
                    {m_valid, s_ready}, 1);
            end
            acc = s_ready;
            @(posedge clk); @(negedge clk);
        end while (!acc);
    endtask

    task automatic run_frame(input int w, input int h, input int l, input int r,
                             input bit byp, input bit hold);
        string rq;
        cfg_width_m1 = 8'(w); cfg_height_m1 = 8'(h);
        cfg_left = 8'(l); cfg_right = 8'(r);
        cfg_bypass = byp; cfg_hold = hold;
        s_valid = 1'b1; s_data = 8'hEE; s_sol = 1'b0; s_eof = 1'b0; m_ready = 1'b1;
        #4;
        // R7: frame-boundary load cycle blocks the stream
        chk(s_ready === 1'b0 && m_valid === 1'b0, "R7", {s_ready, m_valid}, 0);
        @(posedge clk); @(negedge clk);
        if (!hold) begin
            a_w = w; a_h = h; a_l = l; a_r = r; a_b = byp;
        end
        // R7: shadow changes mid-frame must not matter
        cfg_left = ~cfg_left; cfg_right = 8'd0; cfg_bypass = ~byp;
        cfg_width_m1 = 8'd1; cfg_hold = 1'b0;
        rq = hold ? "R8" : (a_b ? "R2" : "R3");
        for (int ln = 0; ln <= a_h; ln++) begin
            for (int c = 0; c <= a_w; c++) begin
                bit in_sol, in_eof, kp, es, ee;
                in_sol = (c == 0);
                in_eof = (ln == a_h) && (c == a_w);
                kp = a_b || (c >= a_l && c + a_r + 1 <= a_w);
                es = a_b ? in_sol : (kp && c == a_l);
                ee = a_b ? in_eof : (kp && (c + a_r + 1 == a_w) && ln == a_h);
                send_pixel(8'((ln * 16 + c) ^ (a_l * 3)), in_sol, in_eof, kp, es, ee, a_b, rq);
            end
        end
        s_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_width_m1 = '0; cfg_height_m1 = '0; cfg_left = '0; cfg_right = '0;
        cfg_bypass = 1'b0; cfg_hold = 1'b0;
        s_valid = 1'b1; s_data = 8'h55; s_sol = 1'b1; s_eof = 1'b0; m_ready = 1'b1;
        repeat (3) @(negedge clk);
        #4;
        // R1: nothing moves during reset
        chk(s_ready === 1'b0 && m_valid === 1'b0, "R1", {s_ready, m_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: held load right after reset keeps the reset config (bypass, 1x1)
        run_frame(5, 1, 1, 1, 0, 1);
        // R2: bypass frame
        run_frame(4, 1, 0, 0, 1, 0);
        // R3..R6, R9: sweep every legal window
        for (int w = 2; w <= 6; w++)
            for (int h = 0; h <= 1; h++)
                for (int l = 0; l <= w - 1; l++)
                    for (int r = 0; r <= w - 1 - l; r++)
                        run_frame(w, h, l, r, 0, 0);
        // R8: held load mid-run keeps the last crop window
        run_frame(7, 2, 3, 0, 0, 1);
        run_frame(3, 2, 0, 0, 1, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule